// File: doc/BRIEF.md
# Timer Compare/Capture Channel with PWM Output

This block is one compare/capture channel that sits beside a shared timer counter. Each timer carries two of them. The channel has one 32-bit threshold register. In compare operation that register sets a PWM duty and marks a compare match. In capture operation the same register latches a timestamp of the counter when an external event arrives. A mode input selects compare or capture. The counter, the bus decode and the interrupt combining live outside this block.

In compare operation the channel produces two kinds of PWM from the shared counter:
- edge-aligned PWM, where the output is high while the counter is below the threshold;
- center-aligned PWM, where the pulse is symmetric about the counter's peak at the reload value.

With a prescaler PSC and a reload value ARR, the PWM period is (PSC+1)*(ARR+1) input clocks, and the duty fraction is threshold/(ARR+1).

The channel raises a one-cycle flag-set strobe for the status flag of its channel. The strobe fires on a fresh compare match or on a capture event. Software writes to the threshold may be applied at once, or held in a shadow register until the counter core signals an update event.

Top module: `tcc_channel`

## Requirements
- R1: In edge mode (`center_i`=0) with the counter enabled, `pwm_o` is high exactly when `cnt_i` < `ccr_o`. `pwm_o` is registered: it reflects the inputs sampled at the previous clock edge.
- R2: In center mode (`center_i`=1) with the counter enabled, `pwm_o` is high exactly when `cnt_i` + `ccr_o` > `arr_i`. The sum is computed without overflow. This gives a pulse centred on `cnt_i` = `arr_i`.
- R3: A threshold of 0 gives a constant low `pwm_o`. A threshold greater than `arr_i` gives a constant high `pwm_o`. Both hold in edge mode and in center mode.
- R4: While `cnt_en_i` is 0, `pwm_o` is low one cycle later.
- R5: In compare operation (`mode_i`=0) with `cnt_en_i`=1, `flag_set_o` pulses for exactly one cycle. The pulse comes one cycle after the first cycle in which `cnt_i` equals `ccr_o`. It does not repeat while the equality persists, and it never fires while `cnt_en_i` is 0.
- R6: In capture operation (`mode_i`=1), `cap_i` passes through a two-flop synchronizer. On its rising edge, `ccr_o` takes the `cnt_i` value present before the third clock edge after `cap_i` rose. `flag_set_o` pulses in that same cycle.
- R7: A level held high on `cap_i`, or a falling edge on it, captures nothing and raises no flag.
- R8: With `preload_i`=0, a write (`ccr_wr_i`=1) places `ccr_wdata_i` in `ccr_o` after the next clock edge.
- R9: With `preload_i`=1, a write is held in a shadow register and `ccr_o` does not change. The shadow value is applied on the next `update_i` pulse. A write arriving together with `update_i` is applied directly. An update with nothing pending leaves `ccr_o` unchanged.
- R10: If a capture and a software write fall in the same cycle, the captured counter value wins.
- R11: After reset, `pwm_o` and `flag_set_o` are 0 and `ccr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, released synchronously by the system |
| cnt_en_i | input | 1 | Counter running |
| cnt_i | input | CNT_W | Current counter value |
| arr_i | input | CNT_W | Reload (period) value of the counter |
| center_i | input | 1 | 1 = center-aligned PWM, 0 = edge-aligned |
| mode_i | input | 1 | 0 = compare, 1 = capture |
| update_i | input | 1 | Update event pulse from the counter core |
| preload_i | input | 1 | 1 = shadow threshold writes until update |
| ccr_wr_i | input | 1 | Software write strobe for the threshold |
| ccr_wdata_i | input | CNT_W | Software write data |
| cap_i | input | 1 | Asynchronous capture event input |
| pwm_o | output | 1 | PWM output |
| flag_set_o | output | 1 | One-cycle strobe to set the channel status flag |
| ccr_o | output | CNT_W | Active threshold / captured value |

## Verification
The bench targets the following corner cases:
- **Threshold extremes in both PWM shapes.** A threshold of zero, or one above the reload value, must pin the output; an off-by-one comparison would let a single-cycle glitch through at the ends of the sweep.
- **Counter held on the match value.** The counter is held on the match value for several cycles, and the counter is enabled while already sitting on the match. A design lacking edge detection would fire the flag repeatedly, or would miss the match seen at enable.
- **Capture input behaviour.** The capture input is held high and then dropped. A level- or both-edge-sensitive design would overwrite the timestamp with a later counter value.
- **Preload ordering.** The bench checks a held preloaded write, an update in the same cycle as a write, and an empty update. Wrong preload ordering would show a stale or premature threshold.
- **Capture against write.** A software write lands in the capture cycle, so a reversed priority would leave the written value in place of the timestamp.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic {
    CC_COMPARE = 1'b0,
    CC_CAPTURE = 1'b1
  } cc_mode_e;
endpackage

// File: rtl/tcc_sync.sv
// Synchronizer chain followed by a rising-edge detector.
module tcc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              last_q, last_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
    last_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= last_d;
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tcc_ccr_reg.sv
// Threshold register with optional shadow; capture load has top priority.
module tcc_ccr_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         preload_i,
  input  logic         update_i,
  input  logic         cap_load_i,
  input  logic [W-1:0] cap_value_i,
  output logic [W-1:0] ccr_o
);
  logic [W-1:0] act_q, act_d;
  logic [W-1:0] shd_q, shd_d;
  logic         pend_q, pend_d;
  logic         shd_wr;

  assign shd_wr = wr_i & preload_i;

  always_comb begin
    act_d  = act_q;
    shd_d  = shd_q;
    pend_d = pend_q;
    if (wr_i && !preload_i) begin
      act_d = wdata_i;
    end
    if (shd_wr) begin
      shd_d  = wdata_i;
      pend_d = 1'b1;
    end
    if (update_i && (pend_q || shd_wr)) begin
      act_d  = shd_wr ? wdata_i : shd_q;
      pend_d = 1'b0;
    end
    if (cap_load_i) begin
      act_d = cap_value_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      shd_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      shd_q  <= shd_d;
      pend_q <= pend_d;
    end
  end

  assign ccr_o = act_q;
endmodule

// File: rtl/tcc_pwm.sv
// Edge- or center-aligned PWM from the shared counter.
module tcc_pwm #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         center_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] arr_i,
  input  logic [W-1:0] ccr_i,
  output logic         pwm_o
);
  localparam int SW = W + 1;

  logic [SW-1:0] sum;
  logic          edge_on, ctr_on;
  logic          pwm_q, pwm_d;

  always_comb begin
    sum     = {1'b0, cnt_i} + {1'b0, ccr_i};
    edge_on = cnt_i < ccr_i;
    ctr_on  = sum > {1'b0, arr_i};
    pwm_d   = en_i & (center_i ? ctr_on : edge_on);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/tcc_event.sv
// Flag-set strobe: first-cycle compare match or capture hit.
module tcc_event #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         cmp_mode_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] ccr_i,
  input  logic         cap_hit_i,
  output logic         flag_set_o
);
  logic eq, eq_q;
  logic flag_q, flag_d;

  always_comb begin
    eq     = en_i & cmp_mode_i & (cnt_i == ccr_i);
    flag_d = (eq & ~eq_q) | cap_hit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eq_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      eq_q   <= eq;
      flag_q <= flag_d;
    end
  end

  assign flag_set_o = flag_q;
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
  import tcc_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic             center_i,
  input  logic             mode_i,
  input  logic             update_i,
  input  logic             preload_i,
  input  logic             ccr_wr_i,
  input  logic [CNT_W-1:0] ccr_wdata_i,
  input  logic             cap_i,
  output logic             pwm_o,
  output logic             flag_set_o,
  output logic [CNT_W-1:0] ccr_o
);
  cc_mode_e         mode;
  logic             cap_rise;
  logic             cap_load;
  logic             is_cmp;
  logic [CNT_W-1:0] ccr;

  assign mode     = cc_mode_e'(mode_i);
  assign is_cmp   = (mode == CC_COMPARE);
  assign cap_load = (mode == CC_CAPTURE) & cap_rise;

  tcc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cap_i), .rise_o(cap_rise)
  );

  tcc_ccr_reg #(.W(CNT_W)) u_ccr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(ccr_wr_i), .wdata_i(ccr_wdata_i),
    .preload_i(preload_i), .update_i(update_i),
    .cap_load_i(cap_load), .cap_value_i(cnt_i),
    .ccr_o(ccr)
  );

  tcc_pwm #(.W(CNT_W)) u_pwm (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cnt_en_i), .center_i(center_i),
    .cnt_i(cnt_i), .arr_i(arr_i), .ccr_i(ccr), .pwm_o(pwm_o)
  );

  tcc_event #(.W(CNT_W)) u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cnt_en_i), .cmp_mode_i(is_cmp),
    .cnt_i(cnt_i), .ccr_i(ccr), .cap_hit_i(cap_load), .flag_set_o(flag_set_o)
  );

  assign ccr_o = ccr;
endmodule

// File: rtl/tcc_channel_chk.sv
module tcc_channel_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_en_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] arr_i,
  input logic             center_i,
  input logic             mode_i,
  input logic             update_i,
  input logic             preload_i,
  input logic             ccr_wr_i,
  input logic             pwm_o,
  input logic             flag_set_o,
  input logic [CNT_W-1:0] ccr_o,
  input logic             cap_rise
);
  p_pwm_idle_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> !pwm_o);

  p_zero_duty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !center_i && ccr_o == '0) |=> !pwm_o);

  p_full_duty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && ccr_o > arr_i && cnt_i <= arr_i) |=> pwm_o);

  p_no_flag_disabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !mode_i) |=> !flag_set_o);

  p_capture_stamp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && cap_rise) |=> (ccr_o == $past(cnt_i) && flag_set_o));

  p_preload_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !update_i && (!ccr_wr_i || preload_i)) |=> $stable(ccr_o));
endmodule

bind tcc_channel tcc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnt_en_i(cnt_en_i), .cnt_i(cnt_i),
  .arr_i(arr_i), .center_i(center_i), .mode_i(mode_i), .update_i(update_i),
  .preload_i(preload_i), .ccr_wr_i(ccr_wr_i), .pwm_o(pwm_o),
  .flag_set_o(flag_set_o), .ccr_o(ccr_o), .cap_rise(cap_rise)
);

// File: tb/tcc_channel_test.sv
module tcc_channel_test;
  localparam int W = 32;
  localparam int K_PWM = 0;
  localparam int K_FLG = 1;
  localparam int K_CCR = 2;

  typedef struct {
    string       req;
    int          kind;
    logic [31:0] exp;
    int          cyc;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         en = 1'b0, center = 1'b0, mode = 1'b0, upd = 1'b0;
  logic         pre = 1'b0, wr = 1'b0, cap = 1'b0;
  logic [W-1:0] cnt = '0, arr = 32'd9, wdata = '0;
  logic         pwm, flag;
  logic [W-1:0] ccr;

  int    cycle = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  item_t q[$];

  always #5 clk = ~clk;

  tcc_channel uut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(en), .cnt_i(cnt), .arr_i(arr),
    .center_i(center), .mode_i(mode), .update_i(upd), .preload_i(pre),
    .ccr_wr_i(wr), .ccr_wdata_i(wdata), .cap_i(cap),
    .pwm_o(pwm), .flag_set_o(flag), .ccr_o(ccr)
  );

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", r, act, exp, cycle);
    end
  endtask

  task automatic push(string r, int k, logic [31:0] e, int d);
    item_t it;
    it.req = r; it.kind = k; it.exp = e; it.cyc = cycle + d;
    q.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write_ccr(logic [W-1:0] v);
    wr = 1'b1; wdata = v; tick(); wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Monitor: pops every expected item due in the cycle just completed.
  initial begin
    forever begin
      @(posedge clk);
      cycle++;
      #2;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].cyc == cycle) begin
          case (q[i].kind)
            K_PWM:   check(q[i].req, {31'd0, pwm}, q[i].exp);
            K_FLG:   check(q[i].req, {31'd0, flag}, q[i].exp);
            default: check(q[i].req, ccr, q[i].exp);
          endcase
          q.delete(i);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    #2;
    check("R11 pwm", {31'd0, pwm}, 0);
    check("R11 flag", {31'd0, flag}, 0);
    check("R11 ccr", ccr, 0);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R8: direct write, CCR = 4
    wr = 1'b1; wdata = 32'd4;
    push("R8 direct write", K_CCR, 4, 1);
    tick(); wr = 1'b0;

    // R1 / R5: edge sweep, every value held two cycles
    en = 1'b1;
    for (int v = 0; v <= 9; v++) begin
      for (int h = 0; h < 2; h++) begin
        cnt = v;
        push("R1 edge pwm", K_PWM, (v < 4) ? 1 : 0, 1);
        push("R5 single match", K_FLG, (v == 4 && h == 0) ? 1 : 0, 1);
        tick();
      end
    end

    // R2: center-aligned, ARR=9, CCR=4 -> high for cnt > 5
    center = 1'b1;
    for (int v = 0; v <= 9; v++) begin
      cnt = v;
      push("R2 center pwm", K_PWM, (v > 5) ? 1 : 0, 1);
      tick();
    end
    for (int v = 8; v >= 0; v--) begin
      cnt = v;
      push("R2 center pwm down", K_PWM, (v > 5) ? 1 : 0, 1);
      tick();
    end

    // R1: down-counting sweep, CCR = 7
    center = 1'b0;
    write_ccr(32'd7);
    for (int v = 9; v >= 0; v--) begin
      cnt = v;
      push("R1 down pwm", K_PWM, (v < 7) ? 1 : 0, 1);
      tick();
    end

    // R3: CCR = 0 and CCR > ARR, both shapes
    write_ccr(32'd0);
    for (int c = 0; c < 2; c++) begin
      center = c[0];
      for (int v = 0; v <= 9; v++) begin
        cnt = v;
        push("R3 zero duty", K_PWM, 0, 1);
        tick();
      end
    end
    write_ccr(32'd12);
    for (int c = 0; c < 2; c++) begin
      center = c[0];
      for (int v = 0; v <= 9; v++) begin
        cnt = v;
        push("R3 full duty", K_PWM, 1, 1);
        tick();
      end
    end
    center = 1'b0;

    // R4: disabled counter forces pwm low
    en = 1'b0; cnt = 3;
    for (int i = 0; i < 3; i++) begin
      push("R4 idle pwm", K_PWM, 0, 1);
      tick();
    end

    // R5: match while disabled, then enable on the match
    write_ccr(32'd3);
    for (int i = 0; i < 2; i++) begin
      push("R5 no flag disabled", K_FLG, 0, 1);
      tick();
    end
    en = 1'b1;
    push("R5 match at enable", K_FLG, 1, 1);
    tick();
    push("R5 no repeat", K_FLG, 0, 1);
    tick();

    // R9: preload
    en = 1'b0; cnt = 0; pre = 1'b1;
    wr = 1'b1; wdata = 32'd7;
    push("R9 held write", K_CCR, 3, 1);
    tick(); wr = 1'b0;
    for (int i = 0; i < 2; i++) begin
      push("R9 still held", K_CCR, 3, 1);
      tick();
    end
    upd = 1'b1;
    push("R9 applied at update", K_CCR, 7, 1);
    tick();
    wr = 1'b1; wdata = 32'd2;
    push("R9 write with update", K_CCR, 2, 1);
    tick(); wr = 1'b0;
    push("R9 empty update", K_CCR, 2, 1);
    tick(); upd = 1'b0; pre = 1'b0;

    // R8: direct write again
    write_ccr(32'd5);
    push("R8 direct write 5", K_CCR, 5, 1);
    tick();

    // R6 / R7: capture
    mode = 1'b1; en = 1'b1; cnt = 55;
    tick(); tick();
    cap = 1'b1;
    push("R6 no early flag", K_FLG, 0, 2);
    push("R6 capture flag", K_FLG, 1, 3);
    push("R6 captured value", K_CCR, 55, 3);
    tick(); tick(); tick();
    cnt = 60;
    for (int i = 0; i < 7; i++) begin
      if (i == 3) cap = 1'b0;
      push("R7 no recapture flag", K_FLG, 0, 1);
      push("R7 value kept", K_CCR, 55, 1);
      tick();
    end

    // R10: capture beats a same-cycle write
    cnt = 77; cap = 1'b1;
    tick(); tick();
    wr = 1'b1; wdata = 32'd999;
    push("R10 capture wins", K_CCR, 77, 1);
    tick(); wr = 1'b0;
    push("R10 capture kept", K_CCR, 77, 1);
    tick();
    cap = 1'b0;
    repeat (5) tick();

    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", q.size());
    end
    finish_run();
  end
endmodule